// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a compact 32-bit integer core built as five overlapping stages: fetch, decode with register read, execute and address generation, data-memory access, and write-back. A set of inter-stage registers carries each instruction's operands and control bits forward one stage per clock, so up to five instructions are in progress at the same time. Instruction storage and data storage are separate arrays, so a fetch and a load or store never compete for a port.

There is no hazard detection, no forwarding between stages and no stalling. The program itself has to keep dependent instructions apart with no-ops. The only exception is the register file, which hands a value being written back straight to a read of the same register in the same cycle. Conditional branches are resolved in the memory stage. A taken branch cancels the three younger instructions already in the pipe. Both memories can be filled through write ports, and the register file and data memory can be read combinationally through two observation ports.

Top module: `pipe5_core`

## Requirements
- R1: After reset, `fetch_pc` advances by 4 on every clock unless a taken branch redirects it. The instruction word is taken from instruction memory at word index `fetch_pc[7:2]`.
- R2: Register-register operations use opcode `[31:26]`=0, sources rs=`[25:21]` and rt=`[20:16]`, and destination rd=`[15:11]`. The function field `[5:0]` selects the operation: 0x20 add, 0x22 subtract (rs−rt), 0x24 and, 0x25 or, 0x2A signed set-less-than (result 1 or 0). Any other function code adds. The all-zero word therefore acts as a no-op.
- R3: Immediate operations take `[15:0]` sign-extended to 32 bits and write rt. Opcode 0x08 adds, 0x0C ands and 0x0D ors.
- R4: A load (opcode 0x23) writes rt with the data word at byte address rs + sign-extended offset. The word index is address bits `[7:2]`.
- R5: A store (opcode 0x2B) writes the value of rt to the data word at rs + sign-extended offset.
- R6: A branch-if-equal (opcode 0x04) whose rs and rt are equal sends fetch to (branch address + 4) + (sign-extended offset << 2). The three instructions that follow the branch in memory have no architectural effect.
- R7: A branch-if-equal whose operands differ has no effect, and the instructions after it execute normally.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: An instruction placed exactly three slots after the instruction that writes its source register reads the new value, because a write-back and a read of the same register in one cycle pass the new value through.
- R10: While reset is held, `fetch_pc` is 0 and `retire_valid` is low. After reset is released, the first instruction retires on the fourth clock.
- R11: In straight-line code, one instruction retires per clock once the pipe has filled. A taken branch leaves exactly three cycles with no retirement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_wr_en | input | 1 | Instruction memory write strobe |
| imem_wr_addr | input | 6 | Instruction memory word index |
| imem_wr_data | input | 32 | Instruction word to write |
| dmem_wr_en | input | 1 | Data memory preload strobe |
| dmem_wr_addr | input | 6 | Data memory preload word index |
| dmem_wr_data | input | 32 | Data word to preload |
| dmem_rd_addr | input | 6 | Data memory observation word index |
| dmem_rd_data | output | 32 | Data memory observation value |
| reg_rd_addr | input | 5 | Register observation index |
| reg_rd_data | output | 32 | Register observation value (0 for register 0) |
| fetch_pc | output | 32 | Current fetch address |
| retire_valid | output | 1 | A non-cancelled instruction is in write-back |
| retire_we | output | 1 | Register write enable in write-back |
| retire_dst | output | 5 | Destination register in write-back |
| retire_data | output | 32 | Value being written back |

## Verification
A write-back to a register and a decode-stage read of that same register can happen in the same cycle. A test provokes this by placing an add-immediate that consumes a register exactly three slots after the instruction that produces it. The test then reads the consumer's destination through the register observation port and compares it with the value built from the new operand. If the old contents had been read instead, the result would be stale or unknown. A second group of tests counts retirements per clock over a fixed window. This shows that a taken branch in the memory stage and the fetch of its target overlap with the cancellation of exactly three younger instructions.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

  localparam int XW = 32;
  localparam int RW = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    ALU_AND = 4'b0000,
    ALU_OR  = 4'b0001,
    ALU_ADD = 4'b0010,
    ALU_SUB = 4'b0110,
    ALU_SLT = 4'b0111
  } alu_op_e;

  // Control bits carried down the pipe; all-zero is a bubble.
  typedef struct packed {
    logic    valid;
    logic    regwrite;
    logic    memread;
    logic    memwrite;
    logic    branch;
    logic    alusrc;
    alu_op_e aluop;
  } ctl_t;

  function automatic logic [XW-1:0] sext16(input logic [15:0] v);
    return {{(XW-16){v[15]}}, v};
  endfunction

  function automatic logic [XW-1:0] br_target(input logic [XW-1:0] pc4,
                                              input logic [XW-1:0] off);
    return pc4 + (off << 2);
  endfunction

  function automatic logic [XW-1:0] alu_eval(input alu_op_e op,
                                             input logic [XW-1:0] a,
                                             input logic [XW-1:0] b);
    case (op)
      ALU_AND: return a & b;
      ALU_OR:  return a | b;
      ALU_ADD: return a + b;
      ALU_SUB: return a - b;
      ALU_SLT: return {{(XW-1){1'b0}}, ($signed(a) < $signed(b))};
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/p5_decode.sv
module p5_decode
  import pipe5_pkg::*;
(
  input  logic          valid,
  input  logic [XW-1:0] instr,
  output ctl_t          ctl,
  output logic [RW-1:0] dst
);
  logic [5:0] opc;
  logic [5:0] fn;

  assign opc = instr[31:26];
  assign fn  = instr[5:0];

  always_comb begin
    ctl       = '0;
    ctl.aluop = ALU_ADD;
    dst       = instr[20:16];
    if (valid) begin
      ctl.valid = 1'b1;
      case (opc)
        OP_RTYPE: begin
          ctl.regwrite = 1'b1;
          dst          = instr[15:11];
          case (fn)
            FN_SUB:  ctl.aluop = ALU_SUB;
            FN_AND:  ctl.aluop = ALU_AND;
            FN_OR:   ctl.aluop = ALU_OR;
            FN_SLT:  ctl.aluop = ALU_SLT;
            default: ctl.aluop = ALU_ADD;
          endcase
        end
        OP_ADDI: begin ctl.regwrite = 1'b1; ctl.alusrc = 1'b1; end
        OP_ANDI: begin ctl.regwrite = 1'b1; ctl.alusrc = 1'b1; ctl.aluop = ALU_AND; end
        OP_ORI:  begin ctl.regwrite = 1'b1; ctl.alusrc = 1'b1; ctl.aluop = ALU_OR; end
        OP_LW:   begin ctl.regwrite = 1'b1; ctl.alusrc = 1'b1; ctl.memread = 1'b1; end
        OP_SW:   begin ctl.alusrc = 1'b1; ctl.memwrite = 1'b1; end
        OP_BEQ:  begin ctl.branch = 1'b1; ctl.aluop = ALU_SUB; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/p5_regfile.sv
module p5_regfile
  import pipe5_pkg::*;
#(
  parameter int NREG = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [RW-1:0] waddr,
  input  logic [XW-1:0] wdata,
  input  logic [RW-1:0] ra1,
  input  logic [RW-1:0] ra2,
  input  logic [RW-1:0] ra3,
  output logic [XW-1:0] rd1,
  output logic [XW-1:0] rd2,
  output logic [XW-1:0] rd3
);
  logic [XW-1:0] regs [NREG];
  logic          wr_live;

  assign wr_live = we && (waddr != '0);

  always_ff @(posedge clk) begin
    if (wr_live) regs[waddr] <= wdata;
  end

  // Write-before-read within the cycle: a pending write reaches the decode reads.
  function automatic logic [XW-1:0] rd_port(input logic [RW-1:0] a);
    if (a == '0)                  return '0;
    else if (wr_live && a == waddr) return wdata;
    else                          return regs[a];
  endfunction

  assign rd1 = rd_port(ra1);
  assign rd2 = rd_port(ra2);
  assign rd3 = (ra3 == '0) ? '0 : regs[ra3];

  AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ra1 == '0) |-> (rd1 == '0)); // R8

  AST_RF_HOLDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (we && waddr != '0) |=> ((ra1 != $past(waddr)) || (we && waddr == ra1) ||
                             (rd1 == $past(wdata)))); // R9
endmodule

// File: rtl/p5_alu.sv
module p5_alu
  import pipe5_pkg::*;
(
  input  alu_op_e       op,
  input  logic [XW-1:0] a,
  input  logic [XW-1:0] b,
  output logic [XW-1:0] y,
  output logic          zero
);
  assign y    = alu_eval(op, a, b);
  assign zero = (y == '0);
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int NREG       = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          imem_wr_en,
  input  logic [$clog2(IMEM_WORDS)-1:0] imem_wr_addr,
  input  logic [31:0]                   imem_wr_data,
  input  logic                          dmem_wr_en,
  input  logic [$clog2(DMEM_WORDS)-1:0] dmem_wr_addr,
  input  logic [31:0]                   dmem_wr_data,
  input  logic [$clog2(DMEM_WORDS)-1:0] dmem_rd_addr,
  output logic [31:0]                   dmem_rd_data,
  input  logic [4:0]                    reg_rd_addr,
  output logic [31:0]                   reg_rd_data,
  output logic [31:0]                   fetch_pc,
  output logic                          retire_valid,
  output logic                          retire_we,
  output logic [4:0]                    retire_dst,
  output logic [31:0]                   retire_data
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);

  logic [XW-1:0] imem [IMEM_WORDS];
  logic [XW-1:0] dmem [DMEM_WORDS];

  // ---------------- fetch ----------------
  logic [XW-1:0] pc, pc4, if_instr;
  logic          redirect;
  logic [XW-1:0] exmem_target;

  assign pc4      = pc + 32'd4;
  assign if_instr = imem[pc[IAW+1:2]];

  always_ff @(posedge clk) begin
    if (imem_wr_en) imem[imem_wr_addr] <= imem_wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst)           pc <= '0;
    else if (redirect) pc <= exmem_target;
    else               pc <= pc4;
  end

  // IF/ID
  logic [XW-1:0] ifid_instr, ifid_pc4;
  logic          ifid_valid;

  always_ff @(posedge clk) begin
    ifid_instr <= if_instr;
    ifid_pc4   <= pc4;
    ifid_valid <= !(rst || redirect);
  end

  // ---------------- decode ----------------
  ctl_t          id_ctl;
  logic [RW-1:0] id_dst;
  logic [XW-1:0] id_a, id_b, id_imm;
  logic [XW-1:0] rf_rd3;
  logic          wb_we;
  logic [RW-1:0] wb_dst;
  logic [XW-1:0] wb_data;

  p5_decode u_dec (
    .valid (ifid_valid),
    .instr (ifid_instr),
    .ctl   (id_ctl),
    .dst   (id_dst)
  );

  p5_regfile #(.NREG(NREG)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (wb_we),
    .waddr (wb_dst),
    .wdata (wb_data),
    .ra1   (ifid_instr[25:21]),
    .ra2   (ifid_instr[20:16]),
    .ra3   (reg_rd_addr),
    .rd1   (id_a),
    .rd2   (id_b),
    .rd3   (rf_rd3)
  );

  assign id_imm = sext16(ifid_instr[15:0]);

  // ID/EX
  ctl_t          idex_ctl;
  logic [XW-1:0] idex_a, idex_b, idex_imm, idex_target;
  logic [RW-1:0] idex_dst;

  always_ff @(posedge clk) begin
    idex_ctl    <= (rst || redirect) ? '0 : id_ctl;
    idex_a      <= id_a;
    idex_b      <= id_b;
    idex_imm    <= id_imm;
    idex_dst    <= id_dst;
    idex_target <= br_target(ifid_pc4, id_imm);
  end

  // ---------------- execute ----------------
  logic [XW-1:0] ex_y;
  logic          ex_zero;

  p5_alu u_alu (
    .op   (idex_ctl.aluop),
    .a    (idex_a),
    .b    (idex_ctl.alusrc ? idex_imm : idex_b),
    .y    (ex_y),
    .zero (ex_zero)
  );

  // EX/MEM
  ctl_t          exmem_ctl;
  logic [XW-1:0] exmem_alu, exmem_store;
  logic [RW-1:0] exmem_dst;
  logic          exmem_zero;

  always_ff @(posedge clk) begin
    exmem_ctl    <= (rst || redirect) ? '0 : idex_ctl;
    exmem_alu    <= ex_y;
    exmem_zero   <= ex_zero;
    exmem_store  <= idex_b;
    exmem_dst    <= idex_dst;
    exmem_target <= idex_target;
  end

  // ---------------- memory ----------------
  logic [DAW-1:0] mem_idx;
  logic [XW-1:0]  mem_rdata;

  assign redirect  = exmem_ctl.branch && exmem_zero;
  assign mem_idx   = exmem_alu[DAW+1:2];
  assign mem_rdata = dmem[mem_idx];

  always_ff @(posedge clk) begin
    if (dmem_wr_en)              dmem[dmem_wr_addr] <= dmem_wr_data;
    else if (exmem_ctl.memwrite) dmem[mem_idx]      <= exmem_store;
  end

  // MEM/WB
  ctl_t          memwb_ctl;
  logic [XW-1:0] memwb_alu, memwb_load;
  logic [RW-1:0] memwb_dst;

  always_ff @(posedge clk) begin
    memwb_ctl  <= rst ? '0 : exmem_ctl;
    memwb_alu  <= exmem_alu;
    memwb_load <= mem_rdata;
    memwb_dst  <= exmem_dst;
  end

  // ---------------- write-back ----------------
  assign wb_we   = memwb_ctl.regwrite;
  assign wb_dst  = memwb_dst;
  assign wb_data = memwb_ctl.memread ? memwb_load : memwb_alu;

  assign fetch_pc     = pc;
  assign retire_valid = memwb_ctl.valid;
  assign retire_we    = wb_we;
  assign retire_dst   = wb_dst;
  assign retire_data  = wb_data;
  assign reg_rd_data  = rf_rd3;
  assign dmem_rd_data = dmem[dmem_rd_addr];

  AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    !redirect |=> (fetch_pc == $past(fetch_pc) + 32'd4)); // R1

  AST_PC_REDIRECT: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (fetch_pc == $past(exmem_target))); // R6

  AST_SQUASH_YOUNGER: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (!ifid_valid && idex_ctl == '0 && exmem_ctl == '0)); // R6

  AST_RESET_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (fetch_pc == '0 && !retire_valid)); // R10

  AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(exmem_ctl.memread && exmem_ctl.memwrite)); // R4
endmodule

// File: tb/test_pipe5_core.sv
module test_pipe5_core;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_wr_en = 1'b0;
  logic [5:0]  imem_wr_addr = '0;
  logic [31:0] imem_wr_data = '0;
  logic        dmem_wr_en = 1'b0;
  logic [5:0]  dmem_wr_addr = '0;
  logic [31:0] dmem_wr_data = '0;
  logic [5:0]  dmem_rd_addr = '0;
  logic [31:0] dmem_rd_data;
  logic [4:0]  reg_rd_addr = '0;
  logic [31:0] reg_rd_data;
  logic [31:0] fetch_pc;
  logic        retire_valid, retire_we;
  logic [4:0]  retire_dst;
  logic [31:0] retire_data;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [31:0] prog [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe5_core i_pipe5_core (
    .clk(clk), .rst(rst),
    .imem_wr_en(imem_wr_en), .imem_wr_addr(imem_wr_addr), .imem_wr_data(imem_wr_data),
    .dmem_wr_en(dmem_wr_en), .dmem_wr_addr(dmem_wr_addr), .dmem_wr_data(dmem_wr_data),
    .dmem_rd_addr(dmem_rd_addr), .dmem_rd_data(dmem_rd_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .fetch_pc(fetch_pc), .retire_valid(retire_valid), .retire_we(retire_we),
    .retire_dst(retire_dst), .retire_data(retire_data)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: run did not finish (act=%0d exp<=20000)", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  task automatic reg_is(input string req, input int r, input logic [31:0] exp);
    reg_rd_addr = r[4:0];
    #1;
    chk(req, reg_rd_data, exp);
  endtask

  task automatic mem_is(input string req, input int w, input logic [31:0] exp);
    dmem_rd_addr = w[5:0];
    #1;
    chk(req, dmem_rd_data, exp);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) prog[i] = 32'h0;
  endtask

  task automatic dmem_put(input int w, input logic [31:0] d);
    @(negedge clk);
    dmem_wr_en = 1'b1; dmem_wr_addr = w[5:0]; dmem_wr_data = d;
    @(negedge clk);
    dmem_wr_en = 1'b0;
  endtask

  // Holds reset, loads the program image, then releases reset at a falling edge.
  task automatic load_and_start();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 64; i++) begin
      imem_wr_en = 1'b1; imem_wr_addr = i[5:0]; imem_wr_data = prog[i];
      @(negedge clk);
    end
    imem_wr_en = 1'b0;
    rst = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 pc held at 0 in reset", fetch_pc, 32'h0);
    chk("R10 no retire in reset", {31'd0, retire_valid}, 32'h0);
  endtask

  task automatic t_alu();
    clear_prog();
    prog[0]  = enc_i(6'h08, 0, 1, 5);
    prog[1]  = enc_i(6'h08, 0, 2, -3);
    prog[2]  = enc_i(6'h08, 0, 11, 7);
    prog[4]  = enc_r(1, 2, 3, 6'h20);
    prog[5]  = enc_i(6'h08, 11, 12, 1);   // three slots after producer of r11
    prog[6]  = enc_r(1, 2, 4, 6'h22);
    prog[7]  = enc_r(1, 2, 5, 6'h24);
    prog[8]  = enc_r(1, 2, 6, 6'h25);
    prog[9]  = enc_r(2, 1, 7, 6'h2A);
    prog[10] = enc_r(1, 2, 8, 6'h2A);
    prog[11] = enc_i(6'h0C, 2, 9, 16'h00F0);
    prog[12] = enc_i(6'h0D, 1, 10, 16'h8000);
    prog[13] = enc_i(6'h08, 0, 0, 9);
    prog[16] = enc_r(0, 0, 13, 6'h20);
    load_and_start();
    run(40);
    reg_is("R3 addi positive", 1, 32'd5);
    reg_is("R3 addi negative sign-extends", 2, 32'hFFFF_FFFD);
    reg_is("R2 add", 3, 32'd2);
    reg_is("R2 sub", 4, 32'd8);
    reg_is("R2 and", 5, 32'd5);
    reg_is("R2 or", 6, 32'hFFFF_FFFD);
    reg_is("R2 slt true signed", 7, 32'd1);
    reg_is("R2 slt false", 8, 32'd0);
    reg_is("R3 andi", 9, 32'h0000_00F0);
    reg_is("R3 ori sign-extended imm", 10, 32'hFFFF_8005);
    reg_is("R9 same-cycle writeback reaches read", 12, 32'd8);
    reg_is("R8 r0 write discarded", 0, 32'd0);
    reg_is("R8 r0 reads zero as operand", 13, 32'd0);
  endtask

  task automatic t_mem();
    clear_prog();
    prog[0] = enc_i(6'h08, 0, 1, 8);
    prog[3] = enc_i(6'h23, 1, 2, 4);
    prog[4] = enc_i(6'h23, 1, 3, -8);
    prog[5] = enc_i(6'h2B, 1, 1, -4);
    prog[6] = enc_i(6'h2B, 0, 2, 16);
    rst = 1'b1;
    dmem_put(0, 32'h1111_2222);
    dmem_put(1, 32'h0);
    dmem_put(3, 32'hCAFE_BABE);
    dmem_put(4, 32'h0);
    load_and_start();
    run(40);
    reg_is("R4 load positive offset", 2, 32'hCAFE_BABE);
    reg_is("R4 load negative offset", 3, 32'h1111_2222);
    mem_is("R5 store negative offset", 1, 32'd8);
    mem_is("R5 store of loaded value", 4, 32'hCAFE_BABE);
  endtask

  task automatic t_branch(input bit taken);
    int base;
    base = taken ? 20 : 24;
    clear_prog();
    prog[0]  = enc_i(6'h08, 0, base, 16'h55);
    prog[1]  = enc_i(6'h08, 0, base+1, 16'h55);
    prog[2]  = enc_i(6'h08, 0, base+2, 16'h55);
    prog[3]  = enc_i(6'h08, 0, 1, 4);
    prog[4]  = enc_i(6'h08, 0, 2, taken ? 4 : 5);
    prog[7]  = enc_i(6'h04, 1, 2, 3);
    prog[8]  = enc_i(6'h08, 0, base, 1);
    prog[9]  = enc_i(6'h08, 0, base+1, 1);
    prog[10] = enc_i(6'h08, 0, base+2, 1);
    prog[11] = enc_i(6'h08, 0, base+3, 16'h77);
    load_and_start();
    run(40);
    if (taken) begin
      reg_is("R6 taken: first younger squashed", base, 32'h55);
      reg_is("R6 taken: third younger squashed", base+2, 32'h55);
      reg_is("R6 taken: target executed", base+3, 32'h77);
    end else begin
      reg_is("R7 not taken: next executes", base, 32'd1);
      reg_is("R7 not taken: third executes", base+2, 32'd1);
      reg_is("R7 not taken: later executes", base+3, 32'h77);
    end
  endtask

  task automatic t_retire(input bit with_branch);
    int cnt;
    cnt = 0;
    clear_prog();
    if (with_branch) prog[0] = enc_i(6'h04, 0, 0, 5);
    load_and_start();
    for (int k = 1; k <= 40; k++) begin
      run(1);
      if (retire_valid) cnt++;
      if (!with_branch && k == 3) chk("R10 nothing retired before fourth clock", {31'd0, retire_valid}, 32'h0);
      if (!with_branch && k == 4) chk("R10 first retire on fourth clock", {31'd0, retire_valid}, 32'h1);
      if (with_branch && k == 6) chk("R11 bubble after taken branch", {31'd0, retire_valid}, 32'h0);
    end
    if (with_branch) chk("R11 taken branch costs three retire slots", cnt, 32'd34);
    else             chk("R11 one retire per clock after fill", cnt, 32'd37);
  endtask

  task automatic t_pc();
    clear_prog();
    load_and_start();
    run(1);
    chk("R1 pc after first clock", fetch_pc, 32'd4);
    run(5);
    chk("R1 pc after six clocks", fetch_pc, 32'd24);
  endtask

  initial begin
    t_reset();
    t_pc();
    t_alu();
    t_mem();
    t_branch(1'b1);
    t_branch(1'b0);
    t_retire(1'b0);
    t_retire(1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule